// File: doc/BRIEF.md
# Pixel Formatter and Word Packer

This block sits on the pixel path of a camera capture unit. Pixels arrive one at a time on a valid/ready handshake and each is reduced to a 16-bit halfword. In colour mode a 24-bit RGB pixel is truncated to RGB 5:6:5. In grayscale mode a 12-bit sample is left-justified in a halfword with four zero bits below it. The halfwords are then packed into 32-bit memory words, which leave on a second valid/ready handshake.

Colour mode and two-pixel grayscale mode put two halfwords in each word, with the first pixel in the upper half. One-pixel grayscale mode puts a single halfword in the upper half of the word and leaves the lower half at zero. A frame-end flag that travels with a pixel closes a half-filled word, so that an odd pixel count never leaves a sample stranded. The block holds at most one waiting halfword and one output word. It applies back-pressure instead of losing data.

Top module: `pixel_packer`

## Requirements
- R1: In colour mode (`mode_gray`=0), in_pixel[23:16] is red, [15:8] green and [7:0] blue. Each pixel becomes the halfword {red[7:3], green[7:2], blue[7:3]}. Low bits are discarded and no rounding is applied.
- R2: In colour mode two consecutive halfwords form one word: the first pixel in out_word[31:16] and the second in out_word[15:0].
- R3: In grayscale mode (`mode_gray`=1) the sample is in_pixel[11:0] and its halfword is {sample, 4'b0000}. With `gray_single`=0, two samples fill one word: the first in [31:16] (bits [11:4] at [31:24], bits [3:0] at [23:20]) and the second in [15:0].
- R4: In grayscale mode with `gray_single`=1, every sample produces its own word {sample, 4'b0000, 16'h0000}.
- R5: When `in_eof`=1 is accepted with the first pixel of a pair, that pixel is emitted at once in [31:16] with [15:0] zero, and the next pixel starts a new word. When `in_eof` comes with the second pixel of a pair, the word is the normal full pair.
- R6: While out_valid=1 and out_ready=0, in_ready is 0 and out_word keeps its value. Every accepted pixel appears in exactly one output word, with none lost or repeated.
- R7: Synchronous active-high reset clears out_valid, sets in_ready and discards any held halfword.
- R8: A word appears on out_valid in the cycle after the clock edge that accepts the pixel completing it. in_ready is 1 whenever the output stage is empty or is being drained in the same cycle.
- R9: `gray_single` has no effect in colour mode: colour pixels are still packed two per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_gray | input | 1 | 0 = RGB 8:8:8 input, 1 = 12-bit grayscale input |
| gray_single | input | 1 | In grayscale mode: 1 = one sample per word, 0 = two |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | 24 | Pixel data (RGB or sample in [11:0]) |
| in_eof | input | 1 | Pixel is the last of its frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 32 | Packed memory word |

## Verification
The hardest situation to reach is a stall that arrives while the first halfword of a pair is waiting, together with a frame end that lands on an odd pixel. Here the held halfword, the output register and the flush path all interact in the same few cycles. The stimulus drives out_ready from a pseudo-random pattern during long colour and grayscale bursts, so stalls fall on both halves of pairs. It also places frame-end flags after odd pixel counts, and it asserts reset while a halfword is held, to show that the held halfword does not leak into the next word.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;

    localparam int PIX_W  = 24;
    localparam int CH_W   = 8;
    localparam int GRAY_W = 12;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PAD_W  = HALF_W - GRAY_W;

    typedef enum logic {
        FMT_RGB  = 1'b0,
        FMT_GRAY = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [4:0] red;
        logic [5:0] green;
        logic [4:0] blue;
    } rgb565_t;

    typedef struct packed {
        logic [HALF_W-1:0] bits;
        logic              last;
        logic              solo;
    } half_t;

    function automatic rgb565_t trunc_565(input logic [CH_W-1:0] r,
                                          input logic [CH_W-1:0] g,
                                          input logic [CH_W-1:0] b);
        rgb565_t o;
        o.red   = r[CH_W-1 -: 5];
        o.green = g[CH_W-1 -: 6];
        o.blue  = b[CH_W-1 -: 5];
        return o;
    endfunction

    function automatic logic [HALF_W-1:0] gray_left(input logic [GRAY_W-1:0] s);
        return {s, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pfmt_convert.sv
module pfmt_convert
    import pfmt_pkg::*;
(
    input  logic [PIX_W-1:0] pixel,
    input  fmt_e             fmt,
    input  logic             single,
    input  logic             eof,
    output half_t            half
);
    rgb565_t           col;
    logic [HALF_W-1:0] gray;
    logic              unused_lsb;

    always_comb begin
        col        = trunc_565(pixel[3*CH_W-1 -: CH_W],
                               pixel[2*CH_W-1 -: CH_W],
                               pixel[CH_W-1:0]);
        gray       = gray_left(pixel[GRAY_W-1:0]);
        unused_lsb = ^pixel[2*CH_W+2:2*CH_W];
    end

    always_comb begin
        half.last = eof;
        if (fmt == FMT_GRAY) begin
            half.bits = gray;
            half.solo = single;
        end else begin
            half.bits = col;
            half.solo = 1'b0;
        end
    end

    // Low four bits of a grayscale halfword are always padding
    always_comb begin
        if (fmt == FMT_GRAY)
            gray_pad_zero_chk: assert (half.bits[PAD_W-1:0] == '0);
    end

endmodule

// File: rtl/pfmt_pair.sv
module pfmt_pair
    import pfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  half_t             half,
    output logic              held,
    output logic              word_load,
    output logic [WORD_W-1:0] word_data
);
    logic              held_q;
    logic [HALF_W-1:0] held_bits_q;

    assign held = held_q;

    always_comb begin
        word_load = 1'b0;
        word_data = '0;
        if (take) begin
            if (held_q) begin
                word_load = 1'b1;
                word_data = {held_bits_q, half.bits};
            end else if (half.solo || half.last) begin
                word_load = 1'b1;
                word_data = {half.bits, {HALF_W{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q      <= 1'b0;
            held_bits_q <= '0;
        end else if (take) begin
            if (held_q) begin
                held_q <= 1'b0;
            end else if (!(half.solo || half.last)) begin
                held_q      <= 1'b1;
                held_bits_q <= half.bits;
            end
        end
    end

    // R2: a held halfword is released by the next accepted pixel
    pair_release_chk: assert property (@(posedge clk) disable iff (rst)
        (held_q && take) |=> !held_q);

    // R5: a frame-end pixel never leaves a halfword held
    eof_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (take && half.last) |=> !held_q);

endmodule

// File: rtl/pfmt_outreg.sv
module pfmt_outreg
    import pfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] data,
    input  logic              ready,
    output logic              valid,
    output logic [WORD_W-1:0] word,
    output logic              space
);
    logic              valid_q;
    logic [WORD_W-1:0] word_q;

    assign valid = valid_q;
    assign word  = word_q;
    assign space = !valid_q || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            word_q  <= data;
        end else if (ready) begin
            valid_q <= 1'b0;
        end
    end

    // R6: a stalled word stays put
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ready) |=> (valid_q && $stable(word_q)));

    // R6: no word is overwritten while stalled
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ready) |-> !load);

endmodule

// File: rtl/pixel_packer.sv
module pixel_packer
    import pfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_gray,
    input  logic              gray_single,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    half_t             half;
    logic              take;
    logic              held;
    logic              word_load;
    logic [WORD_W-1:0] word_data;
    logic              space;
    fmt_e              fmt;

    assign fmt      = mode_gray ? FMT_GRAY : FMT_RGB;
    assign in_ready = space;
    assign take     = in_valid && space;

    pfmt_convert u_convert (
        .pixel  (in_pixel),
        .fmt    (fmt),
        .single (gray_single),
        .eof    (in_eof),
        .half   (half)
    );

    pfmt_pair u_pair (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .half      (half),
        .held      (held),
        .word_load (word_load),
        .word_data (word_data)
    );

    pfmt_outreg u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (word_load),
        .data  (word_data),
        .ready (out_ready),
        .valid (out_valid),
        .word  (out_word),
        .space (space)
    );

    // R6: back-pressure reaches the input
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R4: one-sample grayscale word has an empty lower half
    single_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (take && mode_gray && gray_single && !held) |=> (out_valid && out_word[HALF_W-1:0] == '0));

    // R7: reset leaves the output empty
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !held));

endmodule

// File: tb/test_pixel_packer.sv
module test_pixel_packer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_gray = 1'b0;
    logic        gray_single = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_pixel = '0;
    logic        in_eof = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        bp_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_word = '0;

    pixel_packer i_pixel_packer (
        .clk(clk), .rst(rst), .mode_gray(mode_gray), .gray_single(gray_single),
        .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] e565(input logic [23:0] p);
        return {p[23:19], p[15:10], p[7:3]};
    endfunction

    function automatic logic [15:0] egray(input logic [11:0] s);
        return {s, 4'h0};
    endfunction

    task automatic expect_word(input logic [31:0] w, input string req);
        exp_q.push_back(w);
        tag_q.push_back(req);
    endtask

    task automatic send(input logic [23:0] px, input logic eof);
        in_valid = 1'b1;
        in_pixel = px;
        in_eof   = eof;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 500 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R6 drain", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        @(posedge clk);
        #1;
    endtask

    // output monitor: a word is taken at the edge after a negedge with valid && ready
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 extra word", out_word, 32'h0);
            end else begin
                check(out_word == exp_q[0], tag_q[0], out_word, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
        if (!rst && prev_stall) begin
            check(out_valid && out_word == prev_word, "R6 hold", out_word, prev_word);
            check(!in_ready || !out_valid || out_ready, "R6 in_ready", in_ready, 0);
        end
        prev_stall = !rst && out_valid && !out_ready;
        prev_word  = out_word;
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = bp_en ? lfsr[0] : 1'b1;
        end
    end

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R7 in_ready", in_ready, 1);
        @(posedge clk);
        #1;
    endtask

    task automatic t_rgb();
        mode_gray = 1'b0; gray_single = 1'b0;
        expect_word({e565(24'hFFFFFF), e565(24'h070307)}, "R1 R2 extremes");
        expect_word({e565(24'h12ABCD), e565(24'h80FC08)}, "R1 R2 mixed");
        check({e565(24'h070307), e565(24'hF80400)} == 32'h0000_F820, "R1 table", 0, 0);
        send(24'hFFFFFF, 0); send(24'h070307, 0);
        send(24'h12ABCD, 0); send(24'h80FC08, 1);
        drain();
    endtask

    task automatic t_gray_pair();
        mode_gray = 1'b1; gray_single = 1'b0;
        expect_word({egray(12'hABC), egray(12'h123)}, "R3 pair");
        expect_word({egray(12'hFFF), egray(12'h001)}, "R3 edges");
        send(24'hFFFABC, 0); send(24'h000123, 0);
        send(24'h000FFF, 0); send(24'h555001, 0);
        drain();
    endtask

    task automatic t_gray_single();
        mode_gray = 1'b1; gray_single = 1'b1;
        expect_word(32'hABC0_0000, "R4 one");
        expect_word(32'h0010_0000, "R4 two");
        expect_word(32'hFFF0_0000, "R4 three");
        send(24'h000ABC, 0); send(24'hFFF001, 0); send(24'h000FFF, 0);
        drain();
    endtask

    task automatic t_eof();
        mode_gray = 1'b1; gray_single = 1'b0;
        expect_word({egray(12'h111), egray(12'h222)}, "R5 pair before");
        expect_word({egray(12'h333), 16'h0}, "R5 odd flush");
        expect_word({egray(12'h444), egray(12'h555)}, "R5 new frame");
        send(24'h111, 0); send(24'h222, 0); send(24'h333, 1);
        send(24'h444, 0); send(24'h555, 1);
        mode_gray = 1'b0;
        expect_word({e565(24'hF0F0F0), 16'h0}, "R5 rgb flush");
        send(24'hF0F0F0, 1);
        drain();
    endtask

    task automatic t_rgb_ignores_single();
        mode_gray = 1'b0; gray_single = 1'b1;
        expect_word({e565(24'h345678), e565(24'h9ABCDE)}, "R9 pairs kept");
        send(24'h345678, 0); send(24'h9ABCDE, 0);
        drain();
        gray_single = 1'b0;
    endtask

    task automatic t_latency();
        mode_gray = 1'b1; gray_single = 1'b1;
        expect_word(32'h7770_0000, "R8 word");
        in_valid = 1'b1; in_pixel = 24'h777;
        @(negedge clk);
        check(in_ready == 1'b1, "R8 ready", in_ready, 1);
        check(out_valid == 1'b0, "R8 not yet", out_valid, 0);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R8 next cycle", out_valid, 1);
        drain();
    endtask

    task automatic t_reset_held();
        mode_gray = 1'b0; gray_single = 1'b0;
        send(24'hFFFFFF, 0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        expect_word({e565(24'h204080), 16'h0}, "R7 held cleared");
        send(24'h204080, 1);
        drain();
    endtask

    task automatic t_backpressure();
        logic [23:0] px;
        logic [15:0] first;
        bp_en = 1'b1;
        mode_gray = 1'b0; gray_single = 1'b0;
        for (int i = 0; i < 40; i++) begin
            px = 24'h13579B * (i + 1);
            if (i % 2 == 0) first = e565(px);
            else expect_word({first, e565(px)}, "R6 rgb stall");
            send(px, 0);
        end
        mode_gray = 1'b1;
        for (int i = 0; i < 21; i++) begin
            px = 24'h000ACE + 24'(i * 97);
            if (i == 20) expect_word({egray(px[11:0]), 16'h0}, "R6 gray odd stall");
            else if (i % 2 == 0) first = egray(px[11:0]);
            else expect_word({first, egray(px[11:0])}, "R6 gray stall");
            send(px, i == 20);
        end
        drain();
        bp_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_rgb();
        t_gray_pair();
        t_gray_single();
        t_eof();
        t_rgb_ignores_single();
        t_latency();
        t_reset_held();
        t_backpressure();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule